// File: doc/BRIEF.md
# Compressed-Entry Branch Target Buffer

This block predicts where instruction fetch goes next. It is given the address of a branch and looks that address up in a set-associative table that holds only taken-branch targets. Each entry keeps a valid flag, a shortened tag, the low half of the target address and a flag that marks the branch as a subroutine return. When a lookup finds a matching entry, the block rebuilds the full target by joining the upper bits of the looked-up address to the stored low bits, and it reports whether the branch is a return. When no entry matches, the block predicts the fall-through address and raises a miss flag, which the fetch logic can use to decide whether to stall.

Resolved taken branches are written back through an update port. If the branch already has an entry, that entry is rewritten in place. Otherwise the lowest-numbered empty way of the set is filled, and when the set is full a per-set rotating pointer chooses the way to evict. Tags and targets are cut short to save storage. Two branches that differ only above the tag field share an entry and give a false hit, and a target far from its branch comes back with the wrong upper bits. Both outcomes are accepted because the pipeline corrects mispredictions later.

Top module: `btb_compact`

## Requirements
- R1: After a synchronous reset every entry is empty, so `res_valid` is 0 in the cycle after reset and each later lookup misses until an update is made.
- R2: A lookup that misses returns `res_miss`=1, `res_hit`=0, `res_is_ret`=0 and `res_next_pc` equal to the lookup address plus 4.
- R3: A lookup that hits returns `res_hit`=1 and `res_miss`=0, and `res_next_pc` is lookup address bits [31:16] joined to the stored target bits [15:0]. The result appears in the cycle after the lookup is presented.
- R4: The set index is address bits [7:2] and the stored tag is address bits [19:8]. A lookup address that differs from a stored branch only in bits [31:20] hits that entry (false hit). One that differs in tag bits misses.
- R5: A target whose bits [31:16] differ from those of its branch is stored truncated, and a later hit returns the lookup address's upper bits with the stored low bits.
- R6: `res_is_ret` equals the return flag written with the hitting entry, and it is 0 whenever `res_hit` is 0.
- R7: An update whose address already hits in its set rewrites that way in place, and no other entry of the set is evicted.
- R8: An update that does not hit fills the lowest-numbered invalid way of the set. In a full set it replaces the way named by the set's rotating pointer. That pointer starts at way 0 after reset and advances by one, wrapping, only on such a replacement.
- R9: A lookup and an update to the same set in the same cycle return the contents from before the update. The next lookup sees the new contents.
- R10: `res_valid` is `lk_valid` delayed by one cycle. When `res_valid` is 1, exactly one of `res_hit` and `res_miss` is 1. When `res_valid` is 0, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Branch address to look up |
| upd_valid | input | 1 | Write a resolved taken branch |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Resolved target address |
| upd_is_ret | input | 1 | Resolved branch is a return |
| res_valid | output | 1 | Result valid, one cycle after `lk_valid` |
| res_hit | output | 1 | Lookup found a matching entry |
| res_miss | output | 1 | Lookup found no entry; fetch may stall |
| res_next_pc | output | 32 | Predicted next fetch address |
| res_is_ret | output | 1 | Hitting entry is marked as a return |

## Verification
Every lookup result is due exactly one clock edge after the lookup is presented, and an update takes effect at the edge where it is sampled. The bench drives inputs on the falling edge, lets one rising edge pass, and samples the results on the next falling edge. The next lookup or update is issued only after that sample. For R9 the lookup and the update share one rising edge, so the old contents are expected in that cycle's sample and the new contents in the following lookup.

// File: rtl/btb_pkg.sv
package btb_pkg;
  parameter int unsigned BTB_PC_W    = 32;
  parameter int unsigned BTB_WAYS    = 4;
  parameter int unsigned BTB_SETS    = 64;
  parameter int unsigned BTB_TAG_W   = 12;
  parameter int unsigned BTB_TGT_W   = 16;
  parameter int unsigned BTB_INST_B  = 4;
endpackage

// File: rtl/btb_way.sv
module btb_way #(
  parameter int unsigned SETS  = 64,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned TAG_W = 12,
  parameter int unsigned TGT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_tgt,
  input  logic             wr_ret,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [TGT_W-1:0] rd_tgt,
  output logic             rd_ret,
  input  logic [IDX_W-1:0] pr_idx,
  output logic             pr_valid,
  output logic [TAG_W-1:0] pr_tag
);
  logic [SETS-1:0]  vld;
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [TGT_W-1:0] tgt_mem [SETS];
  logic             ret_mem [SETS];

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !rst) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_tgt;
      ret_mem[wr_idx] <= wr_ret;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_tag <= tag_mem[rd_idx];
      rd_tgt <= tgt_mem[rd_idx];
      rd_ret <= ret_mem[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else if (rd_en) rd_valid <= vld[rd_idx];
  end

  assign pr_valid = vld[pr_idx];
  assign pr_tag   = tag_mem[pr_idx];
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned PTR_W = 2
) (
  input  logic [WAYS-1:0]  way_hit,
  input  logic [WAYS-1:0]  way_valid,
  input  logic [PTR_W-1:0] rr_ptr,
  output logic [PTR_W-1:0] sel_way,
  output logic             replace
);
  logic [PTR_W-1:0] hit_way;
  logic [PTR_W-1:0] free_way;

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w])    hit_way  = PTR_W'(w);
      if (!way_valid[w]) free_way = PTR_W'(w);
    end
    if (|way_hit) begin
      sel_way = hit_way;
      replace = 1'b0;
    end else if (!(&way_valid)) begin
      sel_way = free_way;
      replace = 1'b0;
    end else begin
      sel_way = rr_ptr;
      replace = 1'b1;
    end
  end
endmodule

// File: rtl/btb_compact.sv
module btb_compact #(
  parameter int unsigned PC_W   = btb_pkg::BTB_PC_W,
  parameter int unsigned WAYS   = btb_pkg::BTB_WAYS,
  parameter int unsigned SETS   = btb_pkg::BTB_SETS,
  parameter int unsigned TAG_W  = btb_pkg::BTB_TAG_W,
  parameter int unsigned TGT_W  = btb_pkg::BTB_TGT_W,
  parameter int unsigned INST_B = btb_pkg::BTB_INST_B
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_is_ret,
  output logic            res_valid,
  output logic            res_hit,
  output logic            res_miss,
  output logic [PC_W-1:0] res_next_pc,
  output logic            res_is_ret
);
  localparam int unsigned OFF_W = $clog2(INST_B);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned PTR_W = $clog2(WAYS);
  localparam int unsigned TAG_LO = OFF_W + IDX_W;
  localparam int unsigned TAG_HI = TAG_LO + TAG_W;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] up_tag;
  assign lk_idx = lk_pc[OFF_W +: IDX_W];
  assign up_idx = upd_pc[OFF_W +: IDX_W];
  assign up_tag = upd_pc[TAG_LO +: TAG_W];

  logic unused_bits;
  assign unused_bits = ^{upd_pc[OFF_W-1:0], upd_pc[PC_W-1:TAG_HI], upd_target[PC_W-1:TGT_W]};

  logic [PC_W-1:0] pc_q;
  logic            req_q;
  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= lk_valid;
    if (lk_valid) pc_q <= lk_pc;
  end

  logic [PTR_W-1:0] rr_ptr [SETS];
  logic [PTR_W-1:0] sel_way;
  logic             replace;

  logic [WAYS-1:0]  rd_valid, rd_ret, pr_valid, up_hit, lk_hit;
  logic [TAG_W-1:0] rd_tag [WAYS];
  logic [TAG_W-1:0] pr_tag [WAYS];
  logic [TGT_W-1:0] rd_tgt [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic wr_this;
    assign wr_this = upd_valid && (sel_way == PTR_W'(w));
    btb_way #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_way (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_this),
      .wr_idx   (up_idx),
      .wr_tag   (up_tag),
      .wr_tgt   (upd_target[TGT_W-1:0]),
      .wr_ret   (upd_is_ret),
      .rd_en    (lk_valid),
      .rd_idx   (lk_idx),
      .rd_valid (rd_valid[w]),
      .rd_tag   (rd_tag[w]),
      .rd_tgt   (rd_tgt[w]),
      .rd_ret   (rd_ret[w]),
      .pr_idx   (up_idx),
      .pr_valid (pr_valid[w]),
      .pr_tag   (pr_tag[w])
    );
    assign up_hit[w] = pr_valid[w] && (pr_tag[w] == up_tag);
    assign lk_hit[w] = rd_valid[w] && (rd_tag[w] == pc_q[TAG_LO +: TAG_W]);
  end

  btb_victim #(.WAYS(WAYS), .PTR_W(PTR_W)) u_victim (
    .way_hit   (up_hit),
    .way_valid (pr_valid),
    .rr_ptr    (rr_ptr[up_idx]),
    .sel_way   (sel_way),
    .replace   (replace)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) rr_ptr[s] <= '0;
    end else if (upd_valid && replace) begin
      rr_ptr[up_idx] <= (rr_ptr[up_idx] == PTR_W'(WAYS - 1)) ? '0 : rr_ptr[up_idx] + 1'b1;
    end
  end

  logic [TGT_W-1:0] hit_tgt;
  logic             hit_ret;
  always_comb begin
    hit_tgt = '0;
    hit_ret = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lk_hit[w]) begin
        hit_tgt = rd_tgt[w];
        hit_ret = rd_ret[w];
      end
    end
  end

  assign res_valid   = req_q;
  assign res_hit     = req_q && (|lk_hit);
  assign res_miss    = req_q && !(|lk_hit);
  assign res_is_ret  = res_hit && hit_ret;
  assign res_next_pc = res_hit ? {pc_q[PC_W-1:TGT_W], hit_tgt} : pc_q + PC_W'(INST_B);
endmodule

// File: rtl/btb_compact_chk.sv
module btb_compact_chk #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned TGT_W  = 16,
  parameter int unsigned INST_B = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic [PC_W-1:0] lk_pc,
  input logic            res_valid,
  input logic            res_hit,
  input logic            res_miss,
  input logic [PC_W-1:0] res_next_pc,
  input logic            res_is_ret
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !res_valid);

  p_miss_fallthrough_r2: assert property (@(posedge clk) disable iff (rst)
    res_miss |-> (res_next_pc == $past(lk_pc) + PC_W'(INST_B)));

  p_hit_upper_r5: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (res_next_pc[PC_W-1:TGT_W] == $past(lk_pc[PC_W-1:TGT_W])));

  p_ret_needs_hit_r6: assert property (@(posedge clk) disable iff (rst)
    res_is_ret |-> res_hit);

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($countones({res_hit, res_miss}) == 1));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_hit && !res_miss));
endmodule

bind btb_compact btb_compact_chk #(.PC_W(PC_W), .TGT_W(TGT_W), .INST_B(INST_B)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .lk_valid    (lk_valid),
  .lk_pc       (lk_pc),
  .res_valid   (res_valid),
  .res_hit     (res_hit),
  .res_miss    (res_miss),
  .res_next_pc (res_next_pc),
  .res_is_ret  (res_is_ret)
);

// File: tb/btb_compact_test.sv
`timescale 1ns/1ps
module btb_compact_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [31:0] upd_target = '0;
  logic        upd_is_ret = 1'b0;
  logic        res_valid, res_hit, res_miss, res_is_ret;
  logic [31:0] res_next_pc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  btb_compact uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
    .upd_is_ret(upd_is_ret), .res_valid(res_valid), .res_hit(res_hit),
    .res_miss(res_miss), .res_next_pc(res_next_pc), .res_is_ret(res_is_ret)
  );

  typedef struct packed {
    logic        is_upd;
    logic [31:0] pc;
    logic [31:0] tgt;
    logic        ret;
    logic        ehit;
    logic [31:0] enext;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_1000, 32'h0,          1'b0, 1'b0, 32'h0000_1004, 8'd2}, // R2 empty table
    '{1'b1, 32'h0000_1000, 32'h0000_2340,  1'b0, 1'b0, 32'h0,         8'd3},
    '{1'b0, 32'h0000_1000, 32'h0,          1'b0, 1'b1, 32'h0000_2340, 8'd3}, // R3 plain hit
    '{1'b1, 32'h0000_1104, 32'h0003_8888,  1'b1, 1'b0, 32'h0,         8'd5},
    '{1'b0, 32'h0000_1104, 32'h0,          1'b1, 1'b1, 32'h0000_8888, 8'd5}, // R5 far target, R6 return
    '{1'b0, 32'h5550_1000, 32'h0,          1'b0, 1'b1, 32'h5550_2340, 8'd4}, // R4 false hit
    '{1'b0, 32'h0000_2000, 32'h0,          1'b0, 1'b0, 32'h0000_2004, 8'd4}  // R4 tag differs
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_update(input logic [31:0] pc, input logic [31:0] tgt, input logic ret);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_target = tgt; upd_is_ret = ret;
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic lookup(input string req, input logic [31:0] pc, input logic ehit,
                        input logic [31:0] enext, input logic eret);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc;
    @(posedge clk);
    @(negedge clk);
    check(req, {31'b0, res_hit}, {31'b0, ehit});
    check(req, {31'b0, res_miss}, {31'b0, !ehit});
    check(req, res_next_pc, enext);
    check(req, {31'b0, res_is_ret}, {31'b0, eret});
    lk_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: no result after reset, table empty
    check("R1", {31'b0, res_valid}, 32'd0);
    lookup("R1", 32'h0000_0040, 1'b0, 32'h0000_0044, 1'b0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_upd) do_update(VECS[i].pc, VECS[i].tgt, VECS[i].ret);
      else lookup($sformatf("R%0d", VECS[i].req), VECS[i].pc, VECS[i].ehit,
                  VECS[i].enext, VECS[i].ret);
    end

    // R9: same-cycle lookup and update to one set see old contents
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = 32'h0000_3008; upd_target = 32'h0000_4440; upd_is_ret = 1'b0;
    lk_valid = 1'b1; lk_pc = 32'h0000_3008;
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0; lk_valid = 1'b0;
    check("R9", {31'b0, res_miss}, 32'd1);
    check("R9", res_next_pc, 32'h0000_300C);
    lookup("R9", 32'h0000_3008, 1'b1, 32'h0000_4440, 1'b0);

    // R10: idle cycle gives no result
    @(negedge clk);
    check("R10", {29'b0, res_valid, res_hit, res_miss}, 32'd0);

    // R8: fill set 5, then two rotating replacements
    for (int k = 1; k <= 4; k++) do_update(32'h0000_0014 + k * 32'h1000, 32'h0000_0114 + k * 32'h1000, 1'b0);
    for (int k = 1; k <= 4; k++) lookup("R8", 32'h0000_0014 + k * 32'h1000, 1'b1, 32'h0000_0114 + k * 32'h1000, 1'b0);
    do_update(32'h0000_5014, 32'h0000_5114, 1'b0);
    lookup("R8", 32'h0000_1014, 1'b0, 32'h0000_1018, 1'b0);
    lookup("R8", 32'h0000_5014, 1'b1, 32'h0000_5114, 1'b0);
    do_update(32'h0000_6014, 32'h0000_6114, 1'b0);
    lookup("R8", 32'h0000_2014, 1'b0, 32'h0000_2018, 1'b0);
    lookup("R8", 32'h0000_3014, 1'b1, 32'h0000_3114, 1'b0);

    // R7: in-place rewrite in a full set 9 evicts nothing
    for (int k = 1; k <= 4; k++) do_update(32'h0000_0024 + k * 32'h1000, 32'h0000_0124 + k * 32'h1000, 1'b0);
    do_update(32'h0000_2024, 32'h0000_7770, 1'b1);
    lookup("R7", 32'h0000_1024, 1'b1, 32'h0000_1124, 1'b0);
    lookup("R7", 32'h0000_2024, 1'b1, 32'h0000_7770, 1'b1);

    // R1: reset mid-run empties the table
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    lookup("R1", 32'h0000_1000, 1'b0, 32'h0000_1004, 1'b0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule